// File: doc/BRIEF.md
# Sub-pixel luma interpolation unit

This unit produces the fractional-position reference samples for one 4x4 luma block, as needed by the refinement stage of a motion search. A fetch engine streams a 9x9 window of integer reference pixels into it, one window row per cycle, over a valid/ready handshake. Window column 0 and row 0 sit two pixels left of and above the block's top-left pixel. The unit returns the 4x4 block shifted by a quarter-pel phase (0..3 in each axis), one output row of four samples per handshake. A refinement controller visits candidate positions by choosing the window origin and the phase for each job. It serves the eight half-pel neighbours of the best integer vector first, and then the eight quarter-pel neighbours of the best half-pel point. A larger partition is simply issued as a run of 4x4 jobs.

Half-pel samples come from a separable six-tap filter with weights 1, -5, 20, 20, -5, 1. The horizontal pass runs on every incoming row. Its unclipped results are kept in a short row history, so the vertical pass and the centre sample can be formed as soon as the last tap row arrives. Quarter-pel samples are the rounded mean of two neighbouring integer or half samples. Back-pressure on the output freezes the whole pipeline without losing data.

Top module: `subpel_interp`

## Requirements
- R1: While reset is held, out_valid, job_done and row_ready are low. row_ready is high again by the third clock after reset is released, provided the output is idle.
- R2: With phase (frac_y, frac_x) = (0, 0), output pixel (y, x) equals window pixel at row y+2, column x+2.
- R3: With phase (0, 2), each sample is the horizontal half sample: the taps are window columns x..x+5 of row y+2, with weights 1, -5, 20, 20, -5, 1. The result is rounded as (sum + 16) >> 5 (arithmetic) and clipped to 0..255.
- R4: With phase (2, 0), each sample is the vertical half sample: the same filter over window rows y..y+5 of column x+2, with the same rounding and clipping.
- R5: With phase (2, 2), each sample filters vertically the six unclipped horizontal sums of rows y..y+5. It is rounded as (sum + 512) >> 10 and clipped to 0..255.
- R6: Every other phase gives (a + b + 1) >> 1. Here a and b are the two samples of the half-pel grid cell around the quarter point that have exactly one odd half-grid coordinate. When the quarter point lies on a grid edge, they are the two ends of that edge.
- R7: Window rows 0..4 produce no output. Accepting row k (k = 5..8) makes output row k-5 valid on the next clock. Each job yields exactly four output rows, in row order.
- R8: out_last is high with the fourth output row only. job_done pulses for exactly one clock, the clock after that row's handshake.
- R9: While out_valid is high and out_ready low, row_ready is low and out_pix and out_last hold their values.
- R10: frac_x and frac_y are sampled only with window row 0 of each job. Their values on rows 1..8 have no effect.
- R11: With out_ready held high, one window row is accepted every clock across back-to-back jobs, with no bubbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_valid | input | 1 | Window row present on row_pix |
| row_ready | output | 1 | Unit accepts a window row this clock |
| row_pix | input | 72 | Nine 8-bit pixels; pixel i at bits [8i+7:8i], column 0 leftmost |
| frac_x | input | 2 | Horizontal quarter-pel phase, sampled with row 0 |
| frac_y | input | 2 | Vertical quarter-pel phase, sampled with row 0 |
| out_valid | output | 1 | Output row present on out_pix |
| out_ready | input | 1 | Consumer takes the output row this clock |
| out_pix | output | 32 | Four 8-bit samples; sample x at bits [8x+7:8x] |
| out_last | output | 1 | Marks the fourth output row of a job |
| job_done | output | 1 | One-clock pulse after the last row is taken |

## Verification
The assertions assume that the producer holds row_pix steady while row_valid waits for row_ready. They also assume that every job delivers all nine rows before the next job's first row, so that the checker's own row count lines up with the unit's. The stimulus drives rows only from a task that issues complete nine-row jobs and waits on row_ready before moving on. Random gaps are inserted only between whole rows, and the phase inputs are scrambled only on rows 1..8. The consumer's ready is toggled freely, since the unit must tolerate any pattern there.

// File: rtl/subpel_pkg.sv
`timescale 1ns/1ps
package subpel_pkg;
  localparam int unsigned PIX_W   = 8;
  localparam int unsigned TAPS    = 6;
  localparam int unsigned MID_W   = PIX_W + 7;   // unclipped one-pass sum
  localparam int unsigned ACC_W   = MID_W + 7;   // two-pass sum
  localparam int unsigned SH_ONE  = 5;
  localparam int unsigned SH_TWO  = 2 * SH_ONE;

  typedef logic [PIX_W-1:0]        pix_t;
  typedef logic signed [MID_W-1:0] mid_t;
  typedef logic signed [ACC_W-1:0] acc_t;

  function automatic acc_t widen_pix(input pix_t p);
    return acc_t'({1'b0, p});
  endfunction

  // weights 1,-5,20,20,-5,1 built from shifts and adds
  function automatic acc_t fir6(input acc_t t0, input acc_t t1, input acc_t t2,
                                input acc_t t3, input acc_t t4, input acc_t t5);
    acc_t outer, inner, centre;
    outer  = t0 + t5;
    inner  = t1 + t4;
    centre = t2 + t3;
    return outer - (inner <<< 2) - inner + (centre <<< 4) + (centre <<< 2);
  endfunction

  function automatic pix_t round_clip(input acc_t s, input logic two_pass);
    acc_t r;
    if (two_pass) r = (s + (acc_t'(1) <<< (SH_TWO - 1))) >>> SH_TWO;
    else          r = (s + (acc_t'(1) <<< (SH_ONE - 1))) >>> SH_ONE;
    if (r[ACC_W-1]) return '0;
    if (r > acc_t'((1 << PIX_W) - 1)) return '1;
    return r[PIX_W-1:0];
  endfunction

  function automatic pix_t avg2(input pix_t a, input pix_t b);
    logic [PIX_W:0] s;
    s = {1'b0, a} + {1'b0, b} + (PIX_W+1)'(1);
    return s[PIX_W:1];
  endfunction
endpackage

// File: rtl/subpel_hrow.sv
`timescale 1ns/1ps
module subpel_hrow
  import subpel_pkg::*;
#(
  parameter int unsigned BLK = 4
) (
  input  logic [(BLK+TAPS-1)*PIX_W-1:0] row_pix,
  output pix_t                          full_pel [BLK+1],
  output mid_t                          half_mid [BLK]
);
  localparam int unsigned LEAD = TAPS/2 - 1;

  for (genvar c = 0; c < BLK + 1; c++) begin : g_pel
    assign full_pel[c] = row_pix[(c+LEAD)*PIX_W +: PIX_W];
  end

  for (genvar c = 0; c < BLK; c++) begin : g_mid
    assign half_mid[c] = mid_t'(fir6(widen_pix(row_pix[(c+0)*PIX_W +: PIX_W]),
                                     widen_pix(row_pix[(c+1)*PIX_W +: PIX_W]),
                                     widen_pix(row_pix[(c+2)*PIX_W +: PIX_W]),
                                     widen_pix(row_pix[(c+3)*PIX_W +: PIX_W]),
                                     widen_pix(row_pix[(c+4)*PIX_W +: PIX_W]),
                                     widen_pix(row_pix[(c+5)*PIX_W +: PIX_W])));
  end
endmodule

// File: rtl/subpel_hist.sv
`timescale 1ns/1ps
module subpel_hist
  import subpel_pkg::*;
#(
  parameter int unsigned BLK = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  pix_t in_pel   [BLK+1],
  input  mid_t in_mid   [BLK],
  output pix_t pel_hist [TAPS-1][BLK+1],
  output mid_t mid_hist [TAPS-1][BLK]
);
  localparam int unsigned DEPTH = TAPS - 1;

  // index 0 holds the oldest row
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        for (int c = 0; c < BLK + 1; c++) pel_hist[k][c] <= '0;
        for (int c = 0; c < BLK; c++)     mid_hist[k][c] <= '0;
      end
    end else if (shift_en) begin
      for (int k = 0; k < DEPTH - 1; k++) begin
        pel_hist[k] <= pel_hist[k+1];
        mid_hist[k] <= mid_hist[k+1];
      end
      pel_hist[DEPTH-1] <= in_pel;
      mid_hist[DEPTH-1] <= in_mid;
    end
  end
endmodule

// File: rtl/subpel_col.sv
`timescale 1ns/1ps
module subpel_col
  import subpel_pkg::*;
(
  input  pix_t       pel_a [TAPS],   // column x, rows y-2..y+3
  input  pix_t       pel_b [TAPS],   // column x+1
  input  mid_t       mid_a [TAPS],   // unclipped horizontal sums right of x
  input  logic [1:0] frac_x,
  input  logic [1:0] frac_y,
  output pix_t       q
);
  acc_t       v_left, v_right, v_centre;
  pix_t       grid [3][3];
  logic [1:0] lo_y, hi_y, lo_x, hi_x;
  pix_t       s_a, s_b;

  always_comb begin
    v_left   = fir6(widen_pix(pel_a[0]), widen_pix(pel_a[1]), widen_pix(pel_a[2]),
                    widen_pix(pel_a[3]), widen_pix(pel_a[4]), widen_pix(pel_a[5]));
    v_right  = fir6(widen_pix(pel_b[0]), widen_pix(pel_b[1]), widen_pix(pel_b[2]),
                    widen_pix(pel_b[3]), widen_pix(pel_b[4]), widen_pix(pel_b[5]));
    v_centre = fir6(acc_t'(mid_a[0]), acc_t'(mid_a[1]), acc_t'(mid_a[2]),
                    acc_t'(mid_a[3]), acc_t'(mid_a[4]), acc_t'(mid_a[5]));
    // half-pel grid of the cell: even coordinates are integer pixels
    grid[0][0] = pel_a[2];
    grid[0][1] = round_clip(acc_t'(mid_a[2]), 1'b0);
    grid[0][2] = pel_b[2];
    grid[1][0] = round_clip(v_left, 1'b0);
    grid[1][1] = round_clip(v_centre, 1'b1);
    grid[1][2] = round_clip(v_right, 1'b0);
    grid[2][0] = pel_a[3];
    grid[2][1] = round_clip(acc_t'(mid_a[3]), 1'b0);
    grid[2][2] = pel_b[3];
  end

  always_comb begin
    lo_y = {1'b0, frac_y[1]};
    lo_x = {1'b0, frac_x[1]};
    hi_y = lo_y + {1'b0, frac_y[0]};
    hi_x = lo_x + {1'b0, frac_x[0]};
    if (frac_y[0] && frac_x[0] && (lo_y[0] == lo_x[0])) begin
      s_a = grid[lo_y][hi_x];
      s_b = grid[hi_y][lo_x];
    end else begin
      s_a = grid[lo_y][lo_x];
      s_b = grid[hi_y][hi_x];
    end
    q = avg2(s_a, s_b);   // equal operands on grid points
  end
endmodule

// File: rtl/subpel_interp.sv
`timescale 1ns/1ps
module subpel_interp
  import subpel_pkg::*;
#(
  parameter int unsigned BLK = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          row_valid,
  output logic                          row_ready,
  input  logic [(BLK+TAPS-1)*PIX_W-1:0] row_pix,
  input  logic [1:0]                    frac_x,
  input  logic [1:0]                    frac_y,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [BLK*PIX_W-1:0]          out_pix,
  output logic                          out_last,
  output logic                          job_done
);
  localparam int unsigned WIN   = BLK + TAPS - 1;
  localparam int unsigned FILL  = TAPS - 1;
  localparam int unsigned CNT_W = $clog2(WIN);

  logic [1:0]             sync_q;
  logic                   run;
  logic                   take, emit;
  logic [CNT_W-1:0]       cnt_q, cnt_d;
  logic [1:0]             phx_q, phx_d, phy_q, phy_d;
  logic                   ov_d, last_d, done_d;
  logic [BLK*PIX_W-1:0]   pix_d;

  pix_t cur_pel  [BLK+1];
  mid_t cur_mid  [BLK];
  pix_t pel_hist [TAPS-1][BLK+1];
  mid_t mid_hist [TAPS-1][BLK];
  pix_t col_q    [BLK];

  // reset release aligned to the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign run = sync_q[1];

  subpel_hrow #(.BLK(BLK)) u_hrow (
    .row_pix (row_pix),
    .full_pel(cur_pel),
    .half_mid(cur_mid)
  );

  subpel_hist #(.BLK(BLK)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(take),
    .in_pel  (cur_pel),
    .in_mid  (cur_mid),
    .pel_hist(pel_hist),
    .mid_hist(mid_hist)
  );

  for (genvar c = 0; c < BLK; c++) begin : g_col
    pix_t pel_a [TAPS];
    pix_t pel_b [TAPS];
    mid_t mid_a [TAPS];
    for (genvar k = 0; k < TAPS - 1; k++) begin : g_tap
      assign pel_a[k] = pel_hist[k][c];
      assign pel_b[k] = pel_hist[k][c+1];
      assign mid_a[k] = mid_hist[k][c];
    end
    assign pel_a[TAPS-1] = cur_pel[c];
    assign pel_b[TAPS-1] = cur_pel[c+1];
    assign mid_a[TAPS-1] = cur_mid[c];

    subpel_col u_col (
      .pel_a (pel_a),
      .pel_b (pel_b),
      .mid_a (mid_a),
      .frac_x(phx_q),
      .frac_y(phy_q),
      .q     (col_q[c])
    );
    assign pix_d[c*PIX_W +: PIX_W] = col_q[c];
  end

  // next state
  always_comb begin
    row_ready = run && (!out_valid || out_ready);
    take      = row_valid && row_ready;
    emit      = take && (cnt_q >= CNT_W'(FILL));
    cnt_d     = cnt_q;
    if (take) cnt_d = (cnt_q == CNT_W'(WIN - 1)) ? '0 : cnt_q + CNT_W'(1);
    phx_d     = (take && cnt_q == '0) ? frac_x : phx_q;
    phy_d     = (take && cnt_q == '0) ? frac_y : phy_q;
    ov_d      = emit ? 1'b1 : (out_valid && !out_ready);
    last_d    = (cnt_q == CNT_W'(WIN - 1));
    done_d    = out_valid && out_ready && out_last;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      phx_q     <= '0;
      phy_q     <= '0;
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_last  <= 1'b0;
      job_done  <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      phx_q     <= phx_d;
      phy_q     <= phy_d;
      out_valid <= ov_d;
      job_done  <= done_d;
      if (emit) begin
        out_pix  <= pix_d;
        out_last <= last_d;
      end
    end
  end
endmodule

// File: rtl/subpel_interp_chk.sv
`timescale 1ns/1ps
module subpel_interp_chk
  import subpel_pkg::*;
#(
  parameter int unsigned BLK = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 row_valid,
  input logic                 row_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [BLK*PIX_W-1:0] out_pix,
  input logic                 out_last,
  input logic                 job_done
);
  localparam int unsigned WIN   = BLK + TAPS - 1;
  localparam int unsigned FILL  = TAPS - 1;
  localparam int unsigned CNT_W = $clog2(WIN);

  logic             acc;
  logic [CNT_W-1:0] rows_seen;

  assign acc = row_valid && row_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rows_seen <= '0;
    else if (acc) rows_seen <= (rows_seen == CNT_W'(WIN - 1)) ? '0 : rows_seen + CNT_W'(1);
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix) && $stable(out_last));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !row_ready);

  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (rows_seen < CNT_W'(FILL)) |=> !out_valid);

  p_emit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (rows_seen >= CNT_W'(FILL)) |=> out_valid);

  p_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (rows_seen == CNT_W'(WIN - 1)) |=> out_last);

  p_notlast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (rows_seen >= CNT_W'(FILL)) && (rows_seen != CNT_W'(WIN - 1)) |=> !out_last);

  p_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |-> $past(out_valid && out_ready && out_last));

  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> !job_done);
endmodule

bind subpel_interp subpel_interp_chk #(.BLK(BLK)) u_chk (.*);

// File: tb/sim_subpel_interp.sv
`timescale 1ns/1ps
module sim_subpel_interp;
  localparam int BLK  = 4;
  localparam int PW   = 8;
  localparam int WIN  = 9;
  localparam int FILL = 5;

  logic              clk, rst_n, row_valid, row_ready, out_valid, out_ready, out_last, job_done;
  logic [WIN*PW-1:0] row_pix;
  logic [1:0]        frac_x, frac_y;
  logic [BLK*PW-1:0] out_pix;

  subpel_interp #(.BLK(BLK)) u0 (.*);

  int errors = 0, checks = 0;
  int win [WIN][WIN];
  logic [BLK*PW-1:0] exp_q [$];
  bit                lst_q [$];
  string             tag_q [$];

  bit mon_on = 0, rand_ready = 0, gaps = 0, p1_watch = 0;
  int jobs_sent = 0, done_seen = 0, p1_stalls = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- reference arithmetic ----------------
  function automatic int clip8(int v);
    return (v < 0) ? 0 : ((v > 255) ? 255 : v);
  endfunction
  function automatic int ftap(int a, int b, int c, int d, int e, int f);
    return a - 5*b + 20*c + 20*d - 5*e + f;
  endfunction
  function automatic int gp(int y, int x);
    return win[y+2][x+2];
  endfunction
  function automatic int hraw(int y, int x);
    return ftap(gp(y,x-2), gp(y,x-1), gp(y,x), gp(y,x+1), gp(y,x+2), gp(y,x+3));
  endfunction
  function automatic int hb(int y, int x);
    return clip8((hraw(y,x) + 16) >>> 5);
  endfunction
  function automatic int vh(int y, int x);
    return clip8((ftap(gp(y-2,x), gp(y-1,x), gp(y,x), gp(y+1,x), gp(y+2,x), gp(y+3,x)) + 16) >>> 5);
  endfunction
  function automatic int cj(int y, int x);
    return clip8((ftap(hraw(y-2,x), hraw(y-1,x), hraw(y,x), hraw(y+1,x), hraw(y+2,x),
                       hraw(y+3,x)) + 512) >>> 10);
  endfunction
  function automatic int av(int a, int b);
    return (a + b + 1) / 2;
  endfunction
  function automatic int qsample(int y, int x, int qy, int qx);
    case (qy*4 + qx)
      0:  return gp(y,x);
      1:  return av(gp(y,x), hb(y,x));
      2:  return hb(y,x);
      3:  return av(hb(y,x), gp(y,x+1));
      4:  return av(gp(y,x), vh(y,x));
      5:  return av(hb(y,x), vh(y,x));
      6:  return av(hb(y,x), cj(y,x));
      7:  return av(hb(y,x), vh(y,x+1));
      8:  return vh(y,x);
      9:  return av(vh(y,x), cj(y,x));
      10: return cj(y,x);
      11: return av(cj(y,x), vh(y,x+1));
      12: return av(vh(y,x), gp(y+1,x));
      13: return av(vh(y,x), hb(y+1,x));
      14: return av(cj(y,x), hb(y+1,x));
      default: return av(hb(y+1,x), vh(y,x+1));
    endcase
  endfunction

  // ---------------- job driver ----------------
  task automatic run_job(input int kind, input int fy, input int fx);
    string t;
    for (int r = 0; r < WIN; r++)
      for (int c = 0; c < WIN; c++)
        case (kind)
          1:       win[r][c] = ((c%6==2) || (c%6==3) || (r%6==2) || (r%6==3)) ? 255 : 0;
          2:       win[r][c] = ((c%6==2) || (c%6==3) || (r%6==2) || (r%6==3)) ? 0 : 255;
          3:       win[r][c] = 255;
          default: win[r][c] = int'($urandom_range(255, 0));
        endcase
    if (fy == 0 && fx == 0)      t = "R2";
    else if (fy == 0 && fx == 2) t = "R3";
    else if (fy == 2 && fx == 0) t = "R4";
    else if (fy == 2 && fx == 2) t = "R5";
    else                         t = "R6";
    for (int y = 0; y < BLK; y++) begin
      logic [BLK*PW-1:0] rowv;
      for (int x = 0; x < BLK; x++) rowv[x*PW +: PW] = PW'(qsample(y, x, fy, fx));
      exp_q.push_back(rowv);
      lst_q.push_back(y == BLK-1);
      tag_q.push_back({t, "/R10"});
    end
    jobs_sent++;
    for (int r = 0; r < WIN; r++) begin
      if (gaps && ($urandom_range(2, 0) == 0)) begin
        row_valid = 1'b0;
        @(posedge clk); #1;
      end
      row_valid = 1'b1;
      for (int c = 0; c < WIN; c++) row_pix[c*PW +: PW] = PW'(win[r][c]);
      // phase only counts on row 0; scrambled elsewhere (R10)
      frac_y = (r == 0) ? 2'(fy) : ~2'(fy);
      frac_x = (r == 0) ? 2'(fx) : ~2'(fx);
      @(negedge clk);
      while (!row_ready) @(negedge clk);
      @(posedge clk); #1;
    end
    row_valid = 1'b0;
  endtask

  // ---------------- consumer ----------------
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      out_ready = rand_ready ? ($urandom_range(2, 0) != 0) : 1'b1;
    end
  end

  // ---------------- cycle model and compare ----------------
  bit                ev = 0, done_exp = 0, stalled = 0;
  int                bcnt = 0;
  logic [BLK*PW-1:0] held;

  always @(negedge clk) begin
    if (mon_on) begin
      bit acc, hs, lastf;
      chk(out_valid == ev, "R7 out_valid", longint'(out_valid), longint'(ev));
      chk(row_ready == (!ev || out_ready), "R9 row_ready", longint'(row_ready),
          longint'(!ev || out_ready));
      chk(job_done == done_exp, "R8 job_done", longint'(job_done), longint'(done_exp));
      if (job_done) done_seen++;
      if (stalled) chk(out_pix == held, "R9 held data", longint'(out_pix), longint'(held));
      if (p1_watch && row_valid && !row_ready) p1_stalls++;
      acc   = row_valid && row_ready;
      hs    = out_valid && out_ready;
      lastf = 0;
      if (hs) begin
        if (exp_q.size() == 0) begin
          chk(0, "R7 unexpected row", longint'(out_pix), 0);
        end else begin
          string tg;
          tg    = tag_q.pop_front();
          lastf = lst_q.pop_front();
          chk(out_pix == exp_q[0], tg, longint'(out_pix), longint'(exp_q[0]));
          chk(out_last == lastf, "R8 out_last", longint'(out_last), longint'(lastf));
          void'(exp_q.pop_front());
        end
      end
      stalled  = out_valid && !out_ready;
      held     = out_pix;
      done_exp = hs && lastf;
      ev       = (acc && bcnt >= FILL) ? 1'b1 : (ev && !out_ready);
      if (acc) bcnt = (bcnt == WIN-1) ? 0 : bcnt + 1;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired, %0d rows pending, expected 0", exp_q.size());
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- sequence ----------------
  initial begin
    rst_n = 1'b0; row_valid = 1'b0; row_pix = '0; frac_x = '0; frac_y = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", longint'(out_valid), 0);
    chk(job_done == 1'b0, "R1 job_done in reset", longint'(job_done), 0);
    chk(row_ready == 1'b0, "R1 row_ready in reset", longint'(row_ready), 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(row_ready == 1'b1, "R1 row_ready after release", longint'(row_ready), 1);
    @(posedge clk); #1;
    mon_on = 1;

    // phase A: streaming, no back-pressure (R11)
    p1_watch = 1;
    for (int p = 0; p < 16; p++) run_job(0, p / 4, p % 4);
    run_job(1, 0, 2); run_job(2, 0, 2);
    run_job(1, 2, 0); run_job(2, 2, 0);
    run_job(1, 2, 2); run_job(2, 2, 2);
    run_job(3, 1, 3); run_job(1, 3, 1);
    p1_watch = 0;
    chk(p1_stalls == 0, "R11 stalls without back-pressure", p1_stalls, 0);

    // phase B: random back-pressure and input gaps
    rand_ready = 1; gaps = 1;
    for (int j = 0; j < 24; j++)
      run_job(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)), int'($urandom_range(3, 0)));
    while (exp_q.size() != 0) @(posedge clk);
    rand_ready = 0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk(done_seen == jobs_sent, "R8 done pulse count", done_seen, jobs_sent);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule